// File: doc/BRIEF.md
# Filtered Fault Trip Guard for PWM Outputs

This block protects the outputs of a PWM timer. It watches a small set of external fault lines. Each line has its own enable, active-level select and digital filter. When an enabled line is asserted for long enough to pass its filter, the block drops the gated output enable in that same cycle. The block also records which line caused the trip.

The output enable is a latch. Software raises it with a one-cycle set request, and only a hardware trip lowers it. After a trip the enable stays low until software requests it again. The request is refused while any enabled fault line is still at its active level. Each per-line status flag stays set until software clears it with a one-cycle clear pulse.

Top module: `outen_trip_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_en` is 0 and every bit of `trip_flag` is 0.
- R2: A one-cycle `en_set` pulse, given while no enabled source is at its active level, drives `out_en` to 1 from the following cycle onward.
- R3: A source whose bit in `src_en` is 0 never trips, never sets its flag and never blocks `en_set`, whatever its pin does.
- R4: Source i uses filter code `src_filt[4i+3:4i]`. Code 0 or 1 trips on the first active sample. Code N>1 trips only on the Nth consecutive cycle of active level. Any inactive cycle restarts the count.
- R5: In a cycle where an enabled source trips, `out_en` is 0 in that same cycle. It stays 0 afterwards until a later accepted `en_set`.
- R6: A trip of source i sets `trip_flag[i]` from the next cycle on. A `flag_clr[i]` pulse clears it from the next cycle. When a trip and a clear of the same bit fall in one cycle, the trip wins.
- R7: An `en_set` pulse given while any enabled source is at its active level, filtered or not, is ignored.
- R8: `src_pol[i]` = 1 makes source i active when its pin is high. `src_pol[i]` = 0 makes it active when its pin is low.
- R9: `out_en` only rises in the cycle after an `en_set` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin | input | NUM_SRC | Fault lines, already synchronous to clk |
| src_en | input | NUM_SRC | Per-source enable |
| src_pol | input | NUM_SRC | Per-source active level, 1 = high |
| src_filt | input | NUM_SRC*FILT_W | Per-source filter code, source i in bits [FILT_W*i +: FILT_W] |
| en_set | input | 1 | One-cycle request to raise the output enable |
| flag_clr | input | NUM_SRC | One-cycle per-source flag clear |
| out_en | output | 1 | Gated main output enable |
| trip_flag | output | NUM_SRC | Sticky per-source trip flags |

## Verification
The assertions assume that the fault lines are already synchronous to `clk`, since they feed the output enable through logic alone. They also assume that set and clear requests are single-cycle strobes and that the filter codes do not change while a count is running. The stimulus changes every input only on the falling clock edge. It holds configuration constant through each filter run and gives each request for exactly one cycle. The comparisons are made a few nanoseconds after that edge, once the combinational trip path has settled.

// File: rtl/trip_pkg.sv
package trip_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } trip_level_e;

  // true when the pin sits at the level the polarity selects
  function automatic logic at_level(input logic pin, input trip_level_e lvl);
    return (lvl == LVL_HIGH) ? pin : ~pin;
  endfunction

endpackage

// File: rtl/trip_filter.sv
module trip_filter
  import trip_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              en,
  input  logic              pol,
  input  logic [FILT_W-1:0] code,
  output logic              active,
  output logic              trip
);

  localparam logic [FILT_W-1:0] CNT_MAX = {FILT_W{1'b1}};

  logic [FILT_W-1:0] run_q;
  logic [FILT_W-1:0] run_d;
  logic [FILT_W-1:0] need;
  logic              run_upd;

  always_comb begin
    active  = en & at_level(pin, trip_level_e'(pol));
    need    = (code == '0) ? '0 : code - 1'b1;
    trip    = active & (run_q >= need);
    if (!active) begin
      run_d = '0;
    end else if (run_q == CNT_MAX) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
    run_upd = (run_d != run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_upd) begin
      run_q <= run_d;
    end
  end

  // R4: a filtered trip needs the level to have been present one cycle earlier too
  a_r4_filter_run: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && code > 1) |-> $past(active));

endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trip_vec,
  input  logic [NUM_SRC-1:0] active_vec,
  input  logic               set_req,
  input  logic [NUM_SRC-1:0] flag_clr,
  output logic               en_q,
  output logic [NUM_SRC-1:0] flags_q
);

  logic               any_trip;
  logic               any_active;
  logic               en_d;
  logic               en_upd;
  logic [NUM_SRC-1:0] flags_d;
  logic               flags_upd;

  always_comb begin
    any_trip   = |trip_vec;
    any_active = |active_vec;
    if (any_trip) begin
      en_d = 1'b0;
    end else if (set_req && !any_active) begin
      en_d = 1'b1;
    end else begin
      en_d = en_q;
    end
    en_upd    = (en_d != en_q);
    flags_d   = trip_vec | (flags_q & ~flag_clr);
    flags_upd = (flags_d != flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_upd) begin
      flags_q <= flags_d;
    end
  end

  // R5: after a trip the latched enable is low
  a_r5_trip_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    any_trip |=> !en_q);

  // R7: a set request cannot raise the enable while a source is active
  a_r7_set_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (any_active && !en_q) |=> !en_q);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_flag_chk
      // R6: a flag holds until it is cleared
      a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[gi] && !flag_clr[gi]) |=> flags_q[gi]);
      // R6: a trip always leaves its flag set
      a_r6_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trip_vec[gi] |=> flags_q[gi]);
    end
  endgenerate

endmodule

// File: rtl/outen_trip_guard.sv
module outen_trip_guard #(
  parameter int NUM_SRC = 2,
  parameter int FILT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        brk_pin,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_pol,
  input  logic [NUM_SRC*FILT_W-1:0] src_filt,
  input  logic                      en_set,
  input  logic [NUM_SRC-1:0]        flag_clr,
  output logic                      out_en,
  output logic [NUM_SRC-1:0]        trip_flag
);

  logic [NUM_SRC-1:0] trip_vec;
  logic [NUM_SRC-1:0] active_vec;
  logic               en_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      trip_filter #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (brk_pin[gi]),
        .en     (src_en[gi]),
        .pol    (src_pol[gi]),
        .code   (src_filt[gi*FILT_W +: FILT_W]),
        .active (active_vec[gi]),
        .trip   (trip_vec[gi])
      );
    end
  endgenerate

  trip_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_vec   (trip_vec),
    .active_vec (active_vec),
    .set_req    (en_set),
    .flag_clr   (flag_clr),
    .en_q       (en_q),
    .flags_q    (trip_flag)
  );

  // a trip masks the enable in the same cycle
  assign out_en = en_q & ~(|trip_vec);

  // R9: the enable only rises after a set request
  a_r9_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(en_set));

  // R3: a disabled source never trips
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> (out_en == en_q));

endmodule

// File: tb/outen_trip_guard_test.sv
module outen_trip_guard_test;

  logic       clk;
  logic       rst_n;
  logic [1:0] brk_pin, src_en, src_pol, flag_clr;
  logic [7:0] src_filt;
  logic       en_set;
  logic       out_en;
  logic [1:0] trip_flag;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       out;
    logic [1:0] flg;
    string      tag;
  } exp_t;

  exp_t sb[$];

  outen_trip_guard uut (
    .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .src_en(src_en),
    .src_pol(src_pol), .src_filt(src_filt), .en_set(en_set),
    .flag_clr(flag_clr), .out_en(out_en), .trip_flag(trip_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // driver: apply one cycle of stimulus and queue what must be seen
  task automatic cyc(input logic [1:0] en, input logic [1:0] pol,
                     input logic [3:0] f0, input logic [3:0] f1,
                     input logic [1:0] pins, input logic set,
                     input logic [1:0] clr, input logic eo,
                     input logic [1:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    src_en   = en;
    src_pol  = pol;
    src_filt = {f1, f0};
    brk_pin  = pins;
    en_set   = set;
    flag_clr = clr;
    e.out = eo; e.flg = ef; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare once the cycle has settled
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (out_en !== e.out || trip_flag !== e.flg) begin
          errors++;
          $display("FAIL %s: out_en=%b flags=%b expected out_en=%b flags=%b",
                   e.tag, out_en, trip_flag, e.out, e.flg);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; brk_pin = 2'b00; src_en = 2'b11; src_pol = 2'b11;
    src_filt = 8'h30; en_set = 1'b0; flag_clr = 2'b00;
    #22;
    checks++;
    if (out_en !== 1'b0 || trip_flag !== 2'b00) begin
      errors++;
      $display("FAIL R1 in reset: out_en=%b flags=%b expected 0 00", out_en, trip_flag);
    end
    @(negedge clk); rst_n = 1'b1;
    // src0 code 0, src1 code 3, both active high
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, "R1 after reset");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b1, 2'b00, 1'b0, 2'b00, "R2 set cycle");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, "R2 enabled");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b01, 1'b0, 2'b00, 1'b0, 2'b00, "R5 same-cycle trip");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b0, 2'b01, "R5 R6 held low, flag");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b1, 2'b00, 1'b0, 2'b01, "R9 set cycle");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b01, "R9 resumed");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b01, 1'b1, 2'b01, "R6 clear cycle");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, "R6 cleared");
    // filter of three on src1
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R4 sample 1");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R4 sample 2");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b0, 2'b00, "R4 sample 3 trips");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b1, 2'b00, 1'b0, 2'b10, "R7 set while active");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b0, 2'b10, "R7 set ignored");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b0, 2'b10, "R5 stays low");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b1, 2'b10, 1'b0, 2'b10, "R2 set and clear");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, "R2 R6 back up");
    // interrupted runs never reach three
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R4 run a1");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, "R4 gap");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R4 run b1");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R4 run b2");
    cyc(2'b11, 2'b11, 4'd0, 4'd3, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, "R4 restart");
    // src1 disabled: no trip, no flag
    for (int k = 0; k < 4; k++)
      cyc(2'b01, 2'b11, 4'd0, 4'd3, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R3 disabled source");
    // disabled src1 held active does not block set: drop enable via src0 first
    cyc(2'b01, 2'b11, 4'd0, 4'd0, 2'b11, 1'b0, 2'b00, 1'b0, 2'b00, "R3 src0 trips");
    cyc(2'b01, 2'b11, 4'd0, 4'd0, 2'b10, 1'b1, 2'b01, 1'b0, 2'b01, "R3 set with idle src1");
    cyc(2'b01, 2'b11, 4'd0, 4'd0, 2'b10, 1'b0, 2'b00, 1'b1, 2'b00, "R3 set accepted");
    // active-low src0
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b01, 1'b0, 2'b00, 1'b1, 2'b00, "R8 high is idle");
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, "R8 low trips");
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b01, 1'b0, 2'b00, 1'b0, 2'b01, "R8 flag");
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b01, 1'b1, 2'b01, 1'b0, 2'b01, "R6 clear with set");
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b01, 1'b0, 2'b00, 1'b1, 2'b00, "R6 cleared again");
    // trip and clear together: trip wins
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 2'b01, 1'b0, 2'b00, "R6 trip with clear");
    cyc(2'b01, 2'b00, 4'd0, 4'd0, 2'b01, 1'b0, 2'b00, 1'b0, 2'b01, "R6 trip wins");
    // code 1 acts at once on src1
    cyc(2'b10, 2'b11, 4'd0, 4'd1, 2'b00, 1'b1, 2'b00, 1'b0, 2'b01, "R4 code1 set");
    cyc(2'b10, 2'b11, 4'd0, 4'd1, 2'b10, 1'b0, 2'b00, 1'b0, 2'b01, "R4 code1 trips");
    cyc(2'b10, 2'b11, 4'd0, 4'd1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b11, "R6 both flags");
    @(negedge clk);
    @(negedge clk);
    #5;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule